// File: doc/BRIEF.md
# Directory coherence controller for one shared-cache slice

This block decides the coherence traffic for one shared-cache slice. A lookup stage outside the block reads the directory entry of the requested block and, on a shared-cache miss, the entry of the block being replaced. It then presents a request to this controller: either an access (requesting node, write flag, private-hit and shared-hit flags) or a private-cache eviction. The controller accepts the request and returns the next directory entry one cycle later: a sharer vector, an exclusive-owner id with a valid flag, a modified bit and a shared-dirty bit. It also computes the ordered list of coherence actions the request needs. Each action is tagged with a source node and a destination node.

The actions are handed out one per cycle on a valid/ready channel. The list can cover invalidations with their responses, forwards to an owner or to the nearest sharer, data transfers, grants, writebacks, releases, memory fetches and memory writebacks. It also covers the back-invalidation of private copies when an inclusive shared victim is replaced. New requests are refused until the last action of the current list has been taken. The nodes sit on a 2-D mesh: node `i` has column `i % MESH_X` and row `i / MESH_X`.

Top module: `dir_coherence_ctrl`

## Requirements
- R1: A private hit that is a read, or a write whose requester is the valid exclusive owner, emits no action. The next entry equals the current one, except that a write sets the modified bit.
- R2: A private-hit write by a node that is not the exclusive owner, while other sharers exist, emits two actions per other sharer in ascending node order: invalidate (code 0) from the slice to that sharer, then acknowledge (code 1) from that sharer to the requester. The next entry has the requester as sole sharer and valid owner, with modified set and shared-dirty unchanged.
- R3: The same upgrade with no other sharer emits a single grant (code 5) from the slice to the requester and gives the same next entry as R2.
- R4: A private miss with a shared hit and a valid owner emits forward (code 2) from the slice to the owner, then data (code 3) from the owner to the requester. On a write, the next entry is as in R2.
- R5: The read variant of R4 whose owner is modified adds a writeback (code 4) from the owner to the slice after the data. In every read variant of R4, the next entry adds the requester to the sharers, clears the owner valid flag and the modified bit, and a downgrade of a modified owner sets shared-dirty.
- R6: A write miss to a block held only by sharers (no valid owner) invalidates each sharer in ascending order. The sharer closest to the requester answers with data (code 3) and every other sharer answers with an acknowledge (code 1). Closest means the smallest Manhattan distance between mesh coordinates, with ties going to the lowest node id. The next entry is as in R2.
- R7: A read miss to a block held only by sharers emits forward from the slice to the closest sharer (as defined in R6), then data from that sharer to the requester. The requester joins the sharers and the owner stays invalid.
- R8: A shared hit with an empty sharer vector emits one data action from the slice to the requester. The next entry has the requester as sole sharer and owner, modified equal to the write flag, and shared-dirty unchanged.
- R9: A miss in both levels emits, in this order: memory fetch (code 6) from the slice to the memory node, data from the memory node to the slice, and data from the slice to the requester. The next entry has the requester as sole sharer and owner, modified equal to the write flag, and shared-dirty clear.
- R10: With a valid victim, R9 continues with the back-invalidation. A valid victim owner gets an invalidate and returns a writeback (code 4) if modified, or an acknowledge if clean. Without a victim owner, each victim sharer in ascending order gets an invalidate and returns an acknowledge. A memory writeback (code 7) from the slice to the memory node comes last, only if the victim's shared-dirty was set or a modified owner wrote back.
- R11: An eviction by the modified valid owner emits a writeback from that node to the slice, and the next entry has no sharers, no owner, modified clear and shared-dirty set. Any other eviction emits a release (code 8) from the node to the slice, removes the node from the sharers, and clears the owner valid flag if the node was the owner.
- R12: Actions leave one per accepted handshake and hold all fields while stalled. `act_last` marks the final action, and `act_data` is high exactly for codes 3, 4 and 7. `req_ready` stays low from acceptance until the last action has been taken. `st_valid` pulses in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_evict | input | 1 | 1: private eviction, 0: access |
| req_node | input | NODE_W | Requesting node |
| req_write | input | 1 | Access is a write |
| req_prv_hit | input | 1 | Block present in requester's private cache |
| req_sh_hit | input | 1 | Block present in the shared slice |
| req_slice | input | NODE_W | Node id of this slice |
| req_mem | input | NODE_W | Node id of the memory controller for the block |
| cur_sharers | input | NODES | Current sharer vector |
| cur_own_vld | input | 1 | Current owner valid |
| cur_owner | input | NODE_W | Current exclusive owner |
| cur_mod | input | 1 | Current modified bit |
| cur_shdirty | input | 1 | Current shared-dirty bit |
| vic_valid | input | 1 | A shared victim is being replaced |
| vic_sharers | input | NODES | Victim sharer vector |
| vic_own_vld | input | 1 | Victim owner valid |
| vic_owner | input | NODE_W | Victim exclusive owner |
| vic_mod | input | 1 | Victim modified bit |
| vic_shdirty | input | 1 | Victim shared-dirty bit |
| st_valid | output | 1 | Next-entry outputs valid |
| st_sharers | output | NODES | Next sharer vector |
| st_own_vld | output | 1 | Next owner valid |
| st_owner | output | NODE_W | Next exclusive owner |
| st_mod | output | 1 | Next modified bit |
| st_shdirty | output | 1 | Next shared-dirty bit |
| act_valid | output | 1 | Action present |
| act_ready | input | 1 | Action consumer ready |
| act_type | output | 4 | Action code |
| act_src | output | NODE_W | Action source node |
| act_dst | output | NODE_W | Action destination node |
| act_data | output | 1 | Action carries a data block |
| act_last | output | 1 | Final action of the list |

## Verification
Every request class is driven on a 3x3 mesh: silent hits, upgrades with and without other sharers, forwards from clean and modified owners, misses on shared-only blocks, slice-supplied fills, double misses with each kind of victim, and each kind of eviction. The sharer placements make the nearest-sharer choice come out differently in each case: one case has a three-way distance tie settled by node id, and another has two equally near sharers where the farther-indexed one would be wrong. The victim cases are set up to separate a writeback caused by a modified owner from one caused by shared-dirty alone, and from the case with no writeback. An irregular consumer stall pattern shows whether an action is lost or repeated while the channel is blocked.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [3:0] {
    ACT_INV   = 4'd0,
    ACT_ACK   = 4'd1,
    ACT_FWD   = 4'd2,
    ACT_DATA  = 4'd3,
    ACT_WB    = 4'd4,
    ACT_GRANT = 4'd5,
    ACT_MEMRD = 4'd6,
    ACT_MEMWB = 4'd7,
    ACT_REL   = 4'd8
  } act_kind_e;

  // Manhattan distance between two mesh nodes numbered row by row
  function automatic int hop_dist(input int a, input int b, input int mesh_x);
    int dx;
    int dy;
    dx = (a % mesh_x) - (b % mesh_x);
    dy = (a / mesh_x) - (b / mesh_x);
    if (dx < 0) dx = -dx;
    if (dy < 0) dy = -dy;
    return dx + dy;
  endfunction

  function automatic logic kind_has_data(input act_kind_e k);
    return (k == ACT_DATA) || (k == ACT_WB) || (k == ACT_MEMWB);
  endfunction

endpackage

// File: rtl/dir_closest.sv
module dir_closest #(
  parameter int NODES  = 9,
  parameter int MESH_X = 3,
  parameter int NODE_W = 4
) (
  input  logic [NODE_W-1:0] req_node,
  input  logic [NODES-1:0]  cand,
  output logic [NODE_W-1:0] close_id
);
  import dir_pkg::*;

  always_comb begin
    int best;
    int d;
    logic found;
    best = 0;
    found = 1'b0;
    close_id = '0;
    for (int i = 0; i < NODES; i++) begin
      d = hop_dist(i, int'(req_node), MESH_X);
      if (cand[i] && (NODE_W'(i) != req_node) && (!found || d < best)) begin
        best = d;
        found = 1'b1;
        close_id = NODE_W'(i);
      end
    end
  end
endmodule

// File: rtl/dir_action_gen.sv
module dir_action_gen #(
  parameter int NODES   = 9,
  parameter int NODE_W  = 4,
  parameter int MAX_ACT = 22,
  parameter int CNT_W   = 5
) (
  input  logic                  op_evict,
  input  logic [NODE_W-1:0]     node,
  input  logic                  write,
  input  logic                  prv_hit,
  input  logic                  sh_hit,
  input  logic [NODE_W-1:0]     slice,
  input  logic [NODE_W-1:0]     mem,
  input  logic [NODES-1:0]      cur_sh,
  input  logic                  cur_ov,
  input  logic [NODE_W-1:0]     cur_own,
  input  logic                  cur_mod,
  input  logic                  cur_sd,
  input  logic                  vic_valid,
  input  logic [NODES-1:0]      vic_sh,
  input  logic                  vic_ov,
  input  logic [NODE_W-1:0]     vic_own,
  input  logic                  vic_mod,
  input  logic                  vic_sd,
  input  logic [NODE_W-1:0]     close_id,
  output dir_pkg::act_kind_e    kind [MAX_ACT],
  output logic [NODE_W-1:0]     src  [MAX_ACT],
  output logic [NODE_W-1:0]     dst  [MAX_ACT],
  output logic [CNT_W-1:0]      count,
  output logic [NODES-1:0]      nxt_sh,
  output logic                  nxt_ov,
  output logic [NODE_W-1:0]     nxt_own,
  output logic                  nxt_mod,
  output logic                  nxt_sd
);
  import dir_pkg::*;

  always_comb begin
    int n;
    logic [NODES-1:0] me;
    logic excl;
    logic vdirty;
    n = 0;
    for (int k = 0; k < MAX_ACT; k++) begin
      kind[k] = ACT_INV;
      src[k]  = '0;
      dst[k]  = '0;
    end
    for (int i = 0; i < NODES; i++) me[i] = (node == NODE_W'(i));
    excl    = cur_ov && (cur_own == node);
    vdirty  = vic_sd;
    nxt_sh  = cur_sh;
    nxt_ov  = cur_ov;
    nxt_own = cur_own;
    nxt_mod = cur_mod;
    nxt_sd  = cur_sd;

    if (op_evict) begin
      if (excl && cur_mod) begin
        kind[n] = ACT_WB;  src[n] = node; dst[n] = slice; n++;
        nxt_sh = '0; nxt_ov = 1'b0; nxt_mod = 1'b0; nxt_sd = 1'b1;
      end else begin
        kind[n] = ACT_REL; src[n] = node; dst[n] = slice; n++;
        nxt_sh = cur_sh & ~me;
        if (excl) nxt_ov = 1'b0;
      end
    end else if (prv_hit) begin
      if (!write || excl) begin
        nxt_mod = cur_mod | write;
      end else begin
        if ((cur_sh & ~me) != '0) begin
          for (int i = 0; i < NODES; i++) begin
            if (cur_sh[i] && !me[i]) begin
              kind[n] = ACT_INV; src[n] = slice;        dst[n] = NODE_W'(i); n++;
              kind[n] = ACT_ACK; src[n] = NODE_W'(i);   dst[n] = node;       n++;
            end
          end
        end else begin
          kind[n] = ACT_GRANT; src[n] = slice; dst[n] = node; n++;
        end
        nxt_sh = me; nxt_ov = 1'b1; nxt_own = node; nxt_mod = 1'b1;
      end
    end else if (sh_hit) begin
      if (cur_sh != '0) begin
        if (write) begin
          if (cur_ov) begin
            kind[n] = ACT_FWD;  src[n] = slice;   dst[n] = cur_own; n++;
            kind[n] = ACT_DATA; src[n] = cur_own; dst[n] = node;    n++;
          end else begin
            for (int i = 0; i < NODES; i++) begin
              if (cur_sh[i] && !me[i]) begin
                kind[n] = ACT_INV; src[n] = slice; dst[n] = NODE_W'(i); n++;
                kind[n] = (NODE_W'(i) == close_id) ? ACT_DATA : ACT_ACK;
                src[n] = NODE_W'(i); dst[n] = node; n++;
              end
            end
          end
          nxt_sh = me; nxt_ov = 1'b1; nxt_own = node; nxt_mod = 1'b1;
        end else begin
          if (cur_ov) begin
            kind[n] = ACT_FWD;  src[n] = slice;   dst[n] = cur_own; n++;
            kind[n] = ACT_DATA; src[n] = cur_own; dst[n] = node;    n++;
            if (cur_mod) begin
              kind[n] = ACT_WB; src[n] = cur_own; dst[n] = slice; n++;
              nxt_sd = 1'b1;
            end
          end else begin
            kind[n] = ACT_FWD;  src[n] = slice;    dst[n] = close_id; n++;
            kind[n] = ACT_DATA; src[n] = close_id; dst[n] = node;     n++;
          end
          nxt_sh = cur_sh | me; nxt_ov = 1'b0; nxt_mod = 1'b0;
        end
      end else begin
        kind[n] = ACT_DATA; src[n] = slice; dst[n] = node; n++;
        nxt_sh = me; nxt_ov = 1'b1; nxt_own = node; nxt_mod = write;
      end
    end else begin
      kind[n] = ACT_MEMRD; src[n] = slice; dst[n] = mem;   n++;
      kind[n] = ACT_DATA;  src[n] = mem;   dst[n] = slice; n++;
      kind[n] = ACT_DATA;  src[n] = slice; dst[n] = node;  n++;
      if (vic_valid) begin
        if (vic_ov) begin
          kind[n] = ACT_INV; src[n] = slice; dst[n] = vic_own; n++;
          kind[n] = vic_mod ? ACT_WB : ACT_ACK;
          src[n] = vic_own; dst[n] = slice; n++;
          if (vic_mod) vdirty = 1'b1;
        end else begin
          for (int i = 0; i < NODES; i++) begin
            if (vic_sh[i]) begin
              kind[n] = ACT_INV; src[n] = slice;      dst[n] = NODE_W'(i); n++;
              kind[n] = ACT_ACK; src[n] = NODE_W'(i); dst[n] = slice;      n++;
            end
          end
        end
        if (vdirty) begin
          kind[n] = ACT_MEMWB; src[n] = slice; dst[n] = mem; n++;
        end
      end
      nxt_sh = me; nxt_ov = 1'b1; nxt_own = node; nxt_mod = write; nxt_sd = 1'b0;
    end
    count = CNT_W'(n);
  end
endmodule

// File: rtl/dir_action_queue.sv
module dir_action_queue #(
  parameter int NODE_W  = 4,
  parameter int MAX_ACT = 22,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  dir_pkg::act_kind_e kind_in [MAX_ACT],
  input  logic [NODE_W-1:0]  src_in  [MAX_ACT],
  input  logic [NODE_W-1:0]  dst_in  [MAX_ACT],
  input  logic [CNT_W-1:0]   count_in,
  input  logic               act_ready,
  output logic               act_valid,
  output dir_pkg::act_kind_e act_kind,
  output logic [NODE_W-1:0]  act_src,
  output logic [NODE_W-1:0]  act_dst,
  output logic               act_last
);
  import dir_pkg::*;

  act_kind_e         kind_q [MAX_ACT];
  logic [NODE_W-1:0] src_q  [MAX_ACT];
  logic [NODE_W-1:0] dst_q  [MAX_ACT];
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  ptr_q;

  always_ff @(posedge clk) begin
    if (load) begin
      kind_q <= kind_in;
      src_q  <= src_in;
      dst_q  <= dst_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ptr_q <= '0;
    end else if (load) begin
      cnt_q <= count_in;
      ptr_q <= '0;
    end else if (act_valid && act_ready) begin
      ptr_q <= ptr_q + CNT_W'(1);
    end
  end

  assign act_valid = (ptr_q < cnt_q);
  assign act_kind  = kind_q[ptr_q];
  assign act_src   = src_q[ptr_q];
  assign act_dst   = dst_q[ptr_q];
  assign act_last  = act_valid && ((ptr_q + CNT_W'(1)) == cnt_q);
endmodule

// File: rtl/dir_coherence_ctrl.sv
module dir_coherence_ctrl #(
  parameter int NODES  = 9,
  parameter int MESH_X = 3,
  parameter int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_evict,
  input  logic [NODE_W-1:0] req_node,
  input  logic              req_write,
  input  logic              req_prv_hit,
  input  logic              req_sh_hit,
  input  logic [NODE_W-1:0] req_slice,
  input  logic [NODE_W-1:0] req_mem,
  input  logic [NODES-1:0]  cur_sharers,
  input  logic              cur_own_vld,
  input  logic [NODE_W-1:0] cur_owner,
  input  logic              cur_mod,
  input  logic              cur_shdirty,
  input  logic              vic_valid,
  input  logic [NODES-1:0]  vic_sharers,
  input  logic              vic_own_vld,
  input  logic [NODE_W-1:0] vic_owner,
  input  logic              vic_mod,
  input  logic              vic_shdirty,
  output logic              st_valid,
  output logic [NODES-1:0]  st_sharers,
  output logic              st_own_vld,
  output logic [NODE_W-1:0] st_owner,
  output logic              st_mod,
  output logic              st_shdirty,
  output logic              act_valid,
  input  logic              act_ready,
  output logic [3:0]        act_type,
  output logic [NODE_W-1:0] act_src,
  output logic [NODE_W-1:0] act_dst,
  output logic              act_data,
  output logic              act_last
);
  import dir_pkg::*;

  localparam int MAX_ACT = 2 * NODES + 4;
  localparam int CNT_W   = $clog2(MAX_ACT + 1);

  logic              accept;
  logic [NODE_W-1:0] close_id;
  act_kind_e         gen_kind [MAX_ACT];
  logic [NODE_W-1:0] gen_src  [MAX_ACT];
  logic [NODE_W-1:0] gen_dst  [MAX_ACT];
  logic [CNT_W-1:0]  gen_count;
  logic [NODES-1:0]  nxt_sh;
  logic              nxt_ov;
  logic [NODE_W-1:0] nxt_own;
  logic              nxt_mod;
  logic              nxt_sd;
  act_kind_e         head_kind;

  assign accept = req_valid && req_ready;

  dir_closest #(.NODES(NODES), .MESH_X(MESH_X), .NODE_W(NODE_W)) u_closest (
    .req_node (req_node),
    .cand     (cur_sharers),
    .close_id (close_id)
  );

  dir_action_gen #(.NODES(NODES), .NODE_W(NODE_W), .MAX_ACT(MAX_ACT), .CNT_W(CNT_W)) u_gen (
    .op_evict  (req_evict),
    .node      (req_node),
    .write     (req_write),
    .prv_hit   (req_prv_hit),
    .sh_hit    (req_sh_hit),
    .slice     (req_slice),
    .mem       (req_mem),
    .cur_sh    (cur_sharers),
    .cur_ov    (cur_own_vld),
    .cur_own   (cur_owner),
    .cur_mod   (cur_mod),
    .cur_sd    (cur_shdirty),
    .vic_valid (vic_valid),
    .vic_sh    (vic_sharers),
    .vic_ov    (vic_own_vld),
    .vic_own   (vic_owner),
    .vic_mod   (vic_mod),
    .vic_sd    (vic_shdirty),
    .close_id  (close_id),
    .kind      (gen_kind),
    .src       (gen_src),
    .dst       (gen_dst),
    .count     (gen_count),
    .nxt_sh    (nxt_sh),
    .nxt_ov    (nxt_ov),
    .nxt_own   (nxt_own),
    .nxt_mod   (nxt_mod),
    .nxt_sd    (nxt_sd)
  );

  dir_action_queue #(.NODE_W(NODE_W), .MAX_ACT(MAX_ACT), .CNT_W(CNT_W)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .kind_in   (gen_kind),
    .src_in    (gen_src),
    .dst_in    (gen_dst),
    .count_in  (gen_count),
    .act_ready (act_ready),
    .act_valid (act_valid),
    .act_kind  (head_kind),
    .act_src   (act_src),
    .act_dst   (act_dst),
    .act_last  (act_last)
  );

  assign req_ready = !act_valid;
  assign act_type  = head_kind;
  assign act_data  = act_valid && kind_has_data(head_kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid   <= 1'b0;
      st_sharers <= '0;
      st_own_vld <= 1'b0;
      st_owner   <= '0;
      st_mod     <= 1'b0;
      st_shdirty <= 1'b0;
    end else begin
      st_valid <= accept;
      if (accept) begin
        st_sharers <= nxt_sh;
        st_own_vld <= nxt_ov;
        st_owner   <= nxt_own;
        st_mod     <= nxt_mod;
        st_shdirty <= nxt_sd;
      end
    end
  end
endmodule

// File: rtl/dir_coherence_ctrl_chk.sv
module dir_coherence_ctrl_chk #(
  parameter int NODES  = 9,
  parameter int NODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              req_ready,
  input logic              req_evict,
  input logic              req_write,
  input logic [NODE_W-1:0] req_node,
  input logic              cur_own_vld,
  input logic [NODE_W-1:0] cur_owner,
  input logic              st_valid,
  input logic              st_own_vld,
  input logic [NODE_W-1:0] st_owner,
  input logic              st_mod,
  input logic              act_valid,
  input logic              act_ready,
  input logic [3:0]        act_type,
  input logic [NODE_W-1:0] act_src,
  input logic [NODE_W-1:0] act_dst,
  input logic              act_last
);
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && !act_ready |=> act_valid && $stable(act_type) && $stable(act_src) && $stable(act_dst)); // R12
  AST_LAST_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && act_ready && act_last |=> !act_valid && req_ready); // R12
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> !req_ready); // R12
  AST_STATE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> st_valid); // R12
  AST_WRITE_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_evict && req_write |=> st_own_vld && st_mod && (st_owner == $past(req_node))); // R8
  AST_MEMWB_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && (act_type == 4'd7) |-> act_last); // R10
  AST_EVICT_DROPS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_evict && cur_own_vld && (cur_owner == req_node) |=> !st_own_vld); // R11
endmodule

bind dir_coherence_ctrl dir_coherence_ctrl_chk #(.NODES(NODES), .NODE_W(NODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept      (accept),
  .req_ready   (req_ready),
  .req_evict   (req_evict),
  .req_write   (req_write),
  .req_node    (req_node),
  .cur_own_vld (cur_own_vld),
  .cur_owner   (cur_owner),
  .st_valid    (st_valid),
  .st_own_vld  (st_own_vld),
  .st_owner    (st_owner),
  .st_mod      (st_mod),
  .act_valid   (act_valid),
  .act_ready   (act_ready),
  .act_type    (act_type),
  .act_src     (act_src),
  .act_dst     (act_dst),
  .act_last    (act_last)
);

// File: tb/dir_coherence_ctrl_tb_top.sv
module dir_coherence_ctrl_tb_top;
  localparam int NN = 9;
  localparam int MX = 3;
  localparam int NW = 4;
  localparam int SL = 4;
  localparam int MEM = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_evict = 1'b0, req_write = 1'b0;
  logic req_prv_hit = 1'b0, req_sh_hit = 1'b0;
  logic [NW-1:0] req_node = '0, req_slice, req_mem;
  logic [NN-1:0] cur_sharers = '0, vic_sharers = '0;
  logic cur_own_vld = 1'b0, cur_mod = 1'b0, cur_shdirty = 1'b0;
  logic [NW-1:0] cur_owner = '0, vic_owner = '0;
  logic vic_valid = 1'b0, vic_own_vld = 1'b0, vic_mod = 1'b0, vic_shdirty = 1'b0;
  logic st_valid, st_own_vld, st_mod, st_shdirty;
  logic [NN-1:0] st_sharers;
  logic [NW-1:0] st_owner, act_src, act_dst;
  logic act_valid, act_ready = 1'b0, act_data, act_last;
  logic [3:0] act_type;

  assign req_slice = NW'(SL);
  assign req_mem   = NW'(MEM);

  always #5 clk = ~clk;

  dir_coherence_ctrl #(.NODES(NN), .MESH_X(MX)) dut_i (.*);

  int errors = 0;
  int checks = 0;
  int stall_ctr = 0;
  int qk[$];
  int qs[$];
  int qd[$];
  int e_sh, e_own;
  bit e_ov, e_mod, e_sd;

  task automatic check(input bit ok, input string req, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int manh(input int a, input int b);
    int x, y;
    x = (a % MX) > (b % MX) ? (a % MX) - (b % MX) : (b % MX) - (a % MX);
    y = (a / MX) > (b / MX) ? (a / MX) - (b / MX) : (b / MX) - (a / MX);
    return x + y;
  endfunction

  function automatic int nearest(input int who, input int mask);
    int pick = -1;
    for (int i = 0; i < NN; i++)
      if (mask[i] && i != who)
        if (pick < 0 || manh(i, who) < manh(pick, who)) pick = i;
    return pick;
  endfunction

  task automatic push(input int k, input int s, input int d);
    qk.push_back(k); qs.push_back(s); qd.push_back(d);
  endtask

  task automatic sole(input int who, input bit m);
    e_sh = 1 << who; e_ov = 1; e_own = who; e_mod = m;
  endtask

  // behavioural expectation of actions and next entry
  task automatic predict();
    int n, sh, own, c, mine;
    bit ov, md, w, dirty;
    n = int'(req_node); sh = int'(cur_sharers); ov = cur_own_vld; own = int'(cur_owner);
    md = cur_mod; w = req_write; mine = 1 << n;
    e_sh = sh; e_ov = ov; e_own = own; e_mod = md; e_sd = cur_shdirty;
    if (req_evict) begin
      if (ov && own == n && md) begin
        push(4, n, SL); e_sh = 0; e_ov = 0; e_mod = 0; e_sd = 1;
      end else begin
        push(8, n, SL); e_sh = sh & ~mine;
        if (ov && own == n) e_ov = 0;
      end
    end else if (req_prv_hit) begin
      if (!w || (ov && own == n)) e_mod = md | w;
      else begin
        if ((sh & ~mine) != 0) begin
          for (int i = 0; i < NN; i++) if (sh[i] && i != n) begin push(0, SL, i); push(1, i, n); end
        end else push(5, SL, n);
        sole(n, 1);
      end
    end else if (req_sh_hit) begin
      if (sh != 0) begin
        c = nearest(n, sh);
        if (w) begin
          if (ov) begin push(2, SL, own); push(3, own, n); end
          else for (int i = 0; i < NN; i++) if (sh[i] && i != n) begin
            push(0, SL, i); push(i == c ? 3 : 1, i, n);
          end
          sole(n, 1);
        end else begin
          if (ov) begin
            push(2, SL, own); push(3, own, n);
            if (md) begin push(4, own, SL); e_sd = 1; end
          end else begin push(2, SL, c); push(3, c, n); end
          e_sh = sh | mine; e_ov = 0; e_mod = 0;
        end
      end else begin
        push(3, SL, n); sole(n, w);
      end
    end else begin
      push(6, SL, MEM); push(3, MEM, SL); push(3, SL, n);
      if (vic_valid) begin
        dirty = vic_shdirty;
        if (vic_own_vld) begin
          push(0, SL, int'(vic_owner));
          if (vic_mod) begin push(4, int'(vic_owner), SL); dirty = 1; end
          else push(1, int'(vic_owner), SL);
        end else
          for (int i = 0; i < NN; i++) if (vic_sharers[i]) begin push(0, SL, i); push(1, i, SL); end
        if (dirty) push(7, SL, MEM);
      end
      sole(n, w); e_sd = 0;
    end
  endtask

  task automatic run(input string req);
    int k;
    @(negedge clk);
    predict();
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(st_valid == 1'b1, "R12", "st_valid", int'(st_valid), 1);
    check(int'(st_sharers) == e_sh, req, "sharers", int'(st_sharers), e_sh);
    check(st_own_vld == e_ov, req, "owner valid", int'(st_own_vld), int'(e_ov));
    if (e_ov) check(int'(st_owner) == e_own, req, "owner", int'(st_owner), e_own);
    check(st_mod == e_mod, req, "modified", int'(st_mod), int'(e_mod));
    check(st_shdirty == e_sd, req, "shared-dirty", int'(st_shdirty), int'(e_sd));
    forever begin
      check(act_valid == (qk.size() > 0), req, "act_valid", int'(act_valid), int'(qk.size() > 0));
      check(req_ready == (qk.size() == 0), "R12", "req_ready", int'(req_ready), int'(qk.size() == 0));
      if (qk.size() == 0) break;
      k = qk[0];
      check(int'(act_type) == k, req, "type", int'(act_type), k);
      check(int'(act_src) == qs[0], req, "src", int'(act_src), qs[0]);
      check(int'(act_dst) == qd[0], req, "dst", int'(act_dst), qd[0]);
      check(act_last == (qk.size() == 1), "R12", "last", int'(act_last), int'(qk.size() == 1));
      check(act_data == (k == 3 || k == 4 || k == 7), "R12", "data flag", int'(act_data),
            int'(k == 3 || k == 4 || k == 7));
      act_ready = (stall_ctr % 3) != 2;
      stall_ctr++;
      if (act_ready) begin void'(qk.pop_front()); void'(qs.pop_front()); void'(qd.pop_front()); end
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic cur(input int sh, input bit ov, input int own, input bit md, input bit sd);
    cur_sharers = NN'(sh); cur_own_vld = ov; cur_owner = NW'(own); cur_mod = md; cur_shdirty = sd;
  endtask

  task automatic vic(input bit v, input int sh, input bit ov, input int own, input bit md, input bit sd);
    vic_valid = v; vic_sharers = NN'(sh); vic_own_vld = ov; vic_owner = NW'(own); vic_mod = md; vic_shdirty = sd;
  endtask

  task automatic access(input int n, input bit w, input bit ph, input bit shh, input string req);
    req_evict = 1'b0; req_node = NW'(n); req_write = w; req_prv_hit = ph; req_sh_hit = shh;
    run(req);
  endtask

  task automatic evict(input int n, input string req);
    req_evict = 1'b1; req_node = NW'(n); req_write = 1'b0; req_prv_hit = 1'b1; req_sh_hit = 1'b1;
    run(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(act_valid == 1'b0, "R12", "reset act_valid", int'(act_valid), 0);
    check(req_ready == 1'b1, "R12", "reset req_ready", int'(req_ready), 1);
    check(st_valid == 1'b0, "R12", "reset st_valid", int'(st_valid), 0);
    vic(0, 0, 0, 0, 0, 0);
    // R1: silent read hit, then silent write by owner
    cur(9'h024, 0, 0, 0, 1); access(2, 0, 1, 1, "R1");
    cur(9'h008, 1, 3, 0, 0); access(3, 1, 1, 1, "R1");
    // R2 / R3: upgrades
    cur(9'h092, 0, 0, 0, 0); access(4, 1, 1, 1, "R2");
    cur(9'h010, 0, 0, 0, 1); access(4, 1, 1, 1, "R3");
    // R4 / R5: owner forwards
    cur(9'h100, 1, 8, 1, 0); access(0, 1, 0, 1, "R4");
    cur(9'h100, 1, 8, 1, 0); access(0, 0, 0, 1, "R5");
    cur(9'h100, 1, 8, 0, 0); access(0, 0, 0, 1, "R5");
    // R6: three-way tie at distance 2 from node 0, node 2 wins
    cur(9'h054, 0, 0, 0, 0); access(0, 1, 0, 1, "R6");
    // R7: nodes 5 and 7 both one hop from node 8, node 5 wins; node 1 is farther
    cur(9'h0A2, 0, 0, 0, 0); access(8, 0, 0, 1, "R7");
    cur(9'h181, 0, 0, 0, 0); access(2, 0, 0, 1, "R7");
    // R8: slice supplies data
    cur(9'h000, 0, 0, 0, 1); access(3, 1, 0, 1, "R8");
    cur(9'h000, 0, 0, 0, 0); access(5, 0, 0, 1, "R8");
    // R9 / R10: double misses
    cur(9'h000, 0, 0, 0, 1); vic(0, 0, 0, 0, 0, 0); access(1, 0, 0, 0, "R9");
    vic(1, 9'h080, 1, 7, 1, 0); access(1, 1, 0, 0, "R10");
    vic(1, 9'h109, 0, 0, 0, 0); access(2, 0, 0, 0, "R10");
    vic(1, 9'h000, 0, 0, 0, 1); access(2, 1, 0, 0, "R10");
    vic(1, 9'h020, 1, 5, 0, 1); access(0, 0, 0, 0, "R10");
    vic(0, 0, 0, 0, 0, 0);
    // R11: evictions
    cur(9'h040, 1, 6, 1, 0); evict(6, "R11");
    cur(9'h041, 0, 0, 0, 0); evict(6, "R11");
    cur(9'h008, 1, 3, 0, 0); evict(3, "R11");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule